// File: doc/BRIEF.md
# Challenge-Response Watchdog

This block supervises a host processor with a question-and-answer protocol. It presents a 4-bit question, taken from a pseudo-random sequence, and runs a heartbeat timer. Within each heartbeat period the host must return four answer bytes through a byte-wide register write port. Three bytes go to the answer register. The last byte goes to the sync register, which closes the set and restarts the timer. Each byte must equal a value computed from the current question and the byte's position.

A correct set lowers an error counter by one and moves the question on. A wrong set, or a heartbeat period that expires without a sync write, raises the counter by two and pulses an interrupt. When the counter goes above a programmable threshold, a sticky fault request is raised toward the system's safe-state logic. After reset the watchdog is disabled, and the host arms it with a configuration write. The serial link itself is not part of the block: it appears as single-cycle write strobes carrying a 3-bit address and a data byte.

Top module: `qa_watchdog`

## Requirements
- R1: After reset the watchdog is disabled, `err_cnt` is 0, `irq` and `fault_req` are low, and `question` equals the low four bits of the LFSR seed (default seed 8'hA5, so question 4'h5).
- R2: A write to address 0 sets the enable flag from bit 0 and the error threshold from bits 7:4. Writes to addresses 1 and 2 set the low and high bytes of the heartbeat period, which is 200 cycles after reset. Configuration writes are accepted whether or not the watchdog is enabled.
- R3: The expected byte for answer index i (2 bits) and question q is {q XOR {i,i}, (NOT q) XOR {i[0],i[1],i[1],i[0]}}. Writes to address 3 carry indices 3, 2 and 1 in that order. The sync write to address 4 carries index 0.
- R4: A sync write that follows exactly three answer writes, with all four bytes matching, is a valid set. In the same clock edge `err_cnt` drops by one (it stays at 0 if already 0), the question advances and `irq` stays low.
- R5: A sync write that follows any wrong byte, fewer or more than three answer writes, or bytes in the wrong order is an invalid set. In that edge `err_cnt` rises by two, saturating at its maximum, `irq` is high for exactly one cycle and the question is unchanged.
- R6: While enabled, the heartbeat counter starts at 0 on enable, on each sync write and on each timeout. If no sync write arrives, a timeout occurs on the P-th clock edge after the start, where P is the period (0 acts as 1). A timeout counts as an invalid event as in R5 and discards any partial answer set. A sync write in the same cycle takes precedence over a timeout.
- R7: `fault_req` rises in the edge in which `err_cnt` becomes greater than the threshold and stays high until reset.
- R8: While disabled, answer and sync writes are ignored, and no timeout, counter change or interrupt occurs.
- R9: The question is the low four bits of an 8-bit LFSR that shifts left, taking the new bit 0 from bit7 XOR bit5 XOR bit4 XOR bit3. The LFSR steps only on a valid set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| wr_addr | input | 3 | Register address: 0 config, 1 period low, 2 period high, 3 answer, 4 sync |
| wr_data | input | 8 | Write data byte |
| question | output | 4 | Current question |
| err_cnt | output | ERR_W (4) | Error counter |
| irq | output | 1 | One-cycle pulse per invalid set or timeout |
| fault_req | output | 1 | Sticky fault request (counter above threshold) |

## Verification
The assertions assume that writes are single-cycle strobes sampled on the rising edge, and that reset is held low from time zero until the first edges have passed. They also assume that the error counter is changed only by valid sets, invalid sets and timeouts. The bench drives every write for exactly one cycle from the falling edge and keeps `rst_n` asserted over several initial edges. Its random rounds use a period long enough that no timeout can fall inside a round. Timeouts are produced only in directed sections, where the bench stops writing answers.

// File: rtl/qa_wdg_pkg.sv
package qa_wdg_pkg;

  localparam logic [2:0] ADDR_CFG    = 3'd0;
  localparam logic [2:0] ADDR_PER_LO = 3'd1;
  localparam logic [2:0] ADDR_PER_HI = 3'd2;
  localparam logic [2:0] ADDR_ANS    = 3'd3;
  localparam logic [2:0] ADDR_SYNC   = 3'd4;

  // Expected byte for a given question and answer position.
  function automatic logic [7:0] expected_answer(input logic [3:0] q,
                                                 input logic [1:0] idx);
    expected_answer = {q ^ {idx, idx}, ~q ^ {idx[0], idx[1], idx[1], idx[0]}};
  endfunction

endpackage

// File: rtl/qa_cfg_regs.sv
module qa_cfg_regs #(
  parameter int HB_W       = 16,
  parameter int ERR_W      = 4,
  parameter int PERIOD_RST = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             cfg_en,
  output logic [ERR_W-1:0] cfg_thr,
  output logic [HB_W-1:0]  cfg_period
);
  import qa_wdg_pkg::*;

  localparam int PW = 16;
  localparam logic [PW-1:0] PER_INIT = PW'(PERIOD_RST);

  logic             en_q, en_d;
  logic [ERR_W-1:0] thr_q, thr_d;
  logic [PW-1:0]    per_q, per_d;
  logic             cfg_hit, lo_hit, hi_hit;

  assign cfg_hit = wr_en && (wr_addr == ADDR_CFG);
  assign lo_hit  = wr_en && (wr_addr == ADDR_PER_LO);
  assign hi_hit  = wr_en && (wr_addr == ADDR_PER_HI);

  always_comb begin
    en_d  = en_q;
    thr_d = thr_q;
    per_d = per_q;
    if (cfg_hit) begin
      en_d  = wr_data[0];
      thr_d = ERR_W'(wr_data[7:4]);
    end
    if (lo_hit) per_d[7:0]  = wr_data;
    if (hi_hit) per_d[15:8] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      thr_q <= '0;
      per_q <= PER_INIT;
    end else begin
      if (cfg_hit) begin
        en_q  <= en_d;
        thr_q <= thr_d;
      end
      if (lo_hit || hi_hit) per_q <= per_d;
    end
  end

  assign cfg_en     = en_q;
  assign cfg_thr    = thr_q;
  assign cfg_period = per_q[HB_W-1:0];

endmodule

// File: rtl/qa_question_gen.sv
module qa_question_gen #(
  parameter int          LFSR_W = 8,
  parameter logic [7:0]  SEED   = 8'hA5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       advance,
  output logic [3:0] question
);
  logic [LFSR_W-1:0] lfsr_q, lfsr_d;
  logic              fb;

  assign fb = lfsr_q[7] ^ lfsr_q[5] ^ lfsr_q[4] ^ lfsr_q[3];

  always_comb begin
    lfsr_d = {lfsr_q[LFSR_W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lfsr_q <= LFSR_W'(SEED);
    else if (advance) lfsr_q <= lfsr_d;
  end

  assign question = lfsr_q[3:0];

endmodule

// File: rtl/qa_answer_seq.sv
module qa_answer_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       discard,
  input  logic [3:0] question,
  input  logic       ans_wr,
  input  logic       sync_wr,
  input  logic [7:0] wr_data,
  output logic       set_ok,
  output logic       set_bad
);
  import qa_wdg_pkg::*;

  logic [1:0] cnt_q, cnt_d;
  logic       over_q, over_d;
  logic       bad_q, bad_d;
  logic [7:0] exp_ans, exp_sync;
  logic       upd;

  assign exp_ans  = expected_answer(question, 2'd3 - cnt_q);
  assign exp_sync = expected_answer(question, 2'd0);

  assign set_ok  = sync_wr && !over_q && !bad_q && (cnt_q == 2'd3) &&
                   (wr_data == exp_sync);
  assign set_bad = sync_wr && !set_ok;

  always_comb begin
    cnt_d  = cnt_q;
    over_d = over_q;
    bad_d  = bad_q;
    if (!enable || discard || sync_wr) begin
      cnt_d  = '0;
      over_d = 1'b0;
      bad_d  = 1'b0;
    end else if (ans_wr) begin
      if (cnt_q == 2'd3) begin
        over_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 2'd1;
        if (wr_data != exp_ans) bad_d = 1'b1;
      end
    end
  end

  assign upd = !enable || discard || sync_wr || ans_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (upd) begin
      cnt_q  <= cnt_d;
      over_q <= over_d;
      bad_q  <= bad_d;
    end
  end

endmodule

// File: rtl/qa_hb_timer.sv
module qa_hb_timer #(
  parameter int HB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            restart,
  input  logic [HB_W-1:0] period,
  output logic            timeout,
  output logic [HB_W-1:0] hb_cnt
);
  logic [HB_W-1:0] hb_q, hb_d;
  logic            at_end;

  assign at_end  = ({1'b0, hb_q} + 1'b1) >= {1'b0, period};
  assign timeout = enable && !restart && at_end;

  always_comb begin
    if (!enable || restart || timeout) hb_d = '0;
    else                               hb_d = hb_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hb_q <= '0;
    else        hb_q <= hb_d;
  end

  assign hb_cnt = hb_q;

endmodule

// File: rtl/qa_err_counter.sv
module qa_err_counter #(
  parameter int ERR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ok_evt,
  input  logic             bad_evt,
  input  logic [ERR_W-1:0] thr,
  output logic [ERR_W-1:0] err_cnt,
  output logic             irq,
  output logic             fault_req
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;

  logic [ERR_W-1:0] err_q, err_d;
  logic             irq_q, fault_q, fault_d;

  always_comb begin
    err_d = err_q;
    if (bad_evt) begin
      if (err_q >= ERR_MAX - 1'b1) err_d = ERR_MAX;
      else                         err_d = err_q + 2'd2;
    end else if (ok_evt) begin
      if (err_q != '0) err_d = err_q - 1'b1;
    end
    fault_d = fault_q || (err_d > thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q   <= '0;
      irq_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      err_q   <= err_d;
      irq_q   <= bad_evt;
      fault_q <= fault_d;
    end
  end

  assign err_cnt   = err_q;
  assign irq       = irq_q;
  assign fault_req = fault_q;

endmodule

// File: rtl/qa_watchdog.sv
module qa_watchdog #(
  parameter int         HB_W       = 16,
  parameter int         ERR_W      = 4,
  parameter int         PERIOD_RST = 200,
  parameter int         LFSR_W     = 8,
  parameter logic [7:0] SEED       = 8'hA5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic [3:0]       question,
  output logic [ERR_W-1:0] err_cnt,
  output logic             irq,
  output logic             fault_req
);
  import qa_wdg_pkg::*;

  logic             cfg_en;
  logic [ERR_W-1:0] cfg_thr;
  logic [HB_W-1:0]  cfg_period;
  logic [HB_W-1:0]  hb_cnt;
  logic             ans_wr, sync_wr, timeout;
  logic             set_ok, set_bad, bad_evt;

  assign ans_wr  = cfg_en && wr_en && (wr_addr == ADDR_ANS);
  assign sync_wr = cfg_en && wr_en && (wr_addr == ADDR_SYNC);
  assign bad_evt = set_bad || timeout;

  qa_cfg_regs #(.HB_W(HB_W), .ERR_W(ERR_W), .PERIOD_RST(PERIOD_RST)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg_en(cfg_en), .cfg_thr(cfg_thr),
    .cfg_period(cfg_period)
  );

  qa_question_gen #(.LFSR_W(LFSR_W), .SEED(SEED)) i_qgen (
    .clk(clk), .rst_n(rst_n), .advance(set_ok), .question(question)
  );

  qa_answer_seq i_seq (
    .clk(clk), .rst_n(rst_n), .enable(cfg_en), .discard(timeout),
    .question(question), .ans_wr(ans_wr), .sync_wr(sync_wr),
    .wr_data(wr_data), .set_ok(set_ok), .set_bad(set_bad)
  );

  qa_hb_timer #(.HB_W(HB_W)) i_hb (
    .clk(clk), .rst_n(rst_n), .enable(cfg_en), .restart(sync_wr),
    .period(cfg_period), .timeout(timeout), .hb_cnt(hb_cnt)
  );

  qa_err_counter #(.ERR_W(ERR_W)) i_err (
    .clk(clk), .rst_n(rst_n), .ok_evt(set_ok), .bad_evt(bad_evt),
    .thr(cfg_thr), .err_cnt(err_cnt), .irq(irq), .fault_req(fault_req)
  );

endmodule

// File: rtl/qa_watchdog_chk.sv
module qa_watchdog_chk #(
  parameter int ERR_W = 4,
  parameter int HB_W  = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [3:0]       question,
  input logic [ERR_W-1:0] err_cnt,
  input logic             irq,
  input logic             fault_req,
  input logic             cfg_en,
  input logic [ERR_W-1:0] cfg_thr,
  input logic [HB_W-1:0]  hb_cnt
);
  localparam logic [ERR_W-1:0] EMAX = '1;

  assert_irq_adds_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (err_cnt == (($past(err_cnt) >= EMAX - 1'b1) ? EMAX
                                                         : $past(err_cnt) + 2'd2)));

  assert_quiet_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && (err_cnt != $past(err_cnt))) |-> (err_cnt == $past(err_cnt) - 1'b1));

  assert_question_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == 3'd4)) |=> $stable(question));

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> fault_req);

  assert_fault_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_req) |-> (err_cnt > $past(cfg_thr)));

  assert_idle_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (hb_cnt == '0));

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !$past(cfg_en)) |-> !irq);

endmodule

bind qa_watchdog qa_watchdog_chk #(.ERR_W(ERR_W), .HB_W(HB_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .question(question), .err_cnt(err_cnt), .irq(irq), .fault_req(fault_req),
  .cfg_en(cfg_en), .cfg_thr(cfg_thr), .hb_cnt(hb_cnt)
);

// File: tb/test_qa_watchdog.sv
`timescale 1ns/1ps
module test_qa_watchdog;
  logic       clk, rst_n, wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic [3:0] question;
  logic [3:0] err_cnt;
  logic       irq, fault_req;

  int n_run = 0, n_fail = 0;
  logic [7:0] lfsr_m;
  int err_m, thr_m;
  bit fault_m;

  qa_watchdog i_qa_watchdog (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .question(question), .err_cnt(err_cnt),
    .irq(irq), .fault_req(fault_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] ans_of(input logic [3:0] q, input logic [1:0] i);
    ans_of = {q ^ {i, i}, ~q ^ {i[0], i[1], i[1], i[0]}};
  endfunction

  function automatic logic [7:0] step(input logic [7:0] s);
    step = {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic model_bad();
    err_m = (err_m + 2 > 15) ? 15 : err_m + 2;
    if (err_m > thr_m) fault_m = 1'b1;
  endtask

  task automatic check_state(input string req, input bit exp_irq);
    chk(irq == exp_irq, {req, " irq"}, irq, exp_irq);
    chk(err_cnt == err_m, {req, " err_cnt"}, err_cnt, err_m);
    chk(question == lfsr_m[3:0], {req, " question"}, question, lfsr_m[3:0]);
    chk(fault_req == fault_m, {req, " fault_req"}, fault_req, fault_m);
  endtask

  // kind: 0 correct, 1 wrong byte, 2 too few, 3 too many, 4 swapped order
  task automatic round(input int kind, input int bad_i, input string req);
    logic [3:0] q;
    q = lfsr_m[3:0];
    case (kind)
      0: begin wr(3, ans_of(q,3)); wr(3, ans_of(q,2)); wr(3, ans_of(q,1)); wr(4, ans_of(q,0)); end
      1: begin
        for (int i = 3; i >= 0; i--) begin
          logic [7:0] d;
          d = ans_of(q, 2'(i));
          if (i == bad_i) d = d ^ (8'h01 << ($urandom % 8));
          wr((i == 0) ? 3'd4 : 3'd3, d);
        end
      end
      2: begin wr(3, ans_of(q,3)); wr(3, ans_of(q,2)); wr(4, ans_of(q,0)); end
      3: begin wr(3, ans_of(q,3)); wr(3, ans_of(q,2)); wr(3, ans_of(q,1)); wr(3, ans_of(q,1)); wr(4, ans_of(q,0)); end
      default: begin wr(3, ans_of(q,2)); wr(3, ans_of(q,3)); wr(3, ans_of(q,1)); wr(4, ans_of(q,0)); end
    endcase
    if (kind == 0) begin
      err_m = (err_m > 0) ? err_m - 1 : 0;
      lfsr_m = step(lfsr_m);
      if (err_m > thr_m) fault_m = 1'b1;
      check_state(req, 1'b0);
    end else begin
      model_bad();
      check_state(req, 1'b1);
    end
    @(negedge clk);
    chk(irq == 1'b0, {req, " irq one cycle"}, irq, 0);
  endtask

  task automatic wait_timeout(input int p, input string req);
    int n;
    n = 0;
    while (n < p + 5) begin
      @(negedge clk);
      n++;
      if (irq) break;
    end
    chk(n == p, {req, " timeout cycle"}, n, p);
    model_bad();
    check_state(req, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed));
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    lfsr_m = 8'hA5; err_m = 0; thr_m = 0; fault_m = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1 reset", 1'b0);

    // R8: disabled, answers and sync ignored, no timeout beyond default period
    wr(3, ans_of(4'h5,3)); wr(3, 8'h00); wr(4, 8'hFF); wr(4, ans_of(4'h5,0));
    repeat (250) @(negedge clk);
    check_state("R8 disabled", 1'b0);

    // R2: program period 1000 and threshold 3, enable
    wr(1, 8'hE8); wr(2, 8'h03);
    thr_m = 3; wr(0, 8'h31);

    round(0, 0, "R4 valid at zero");        // R3 R9 too
    round(1, 3, "R5 wrong byte idx3");
    round(1, 0, "R5 wrong sync byte");      // err 4 > 3: R7
    round(0, 0, "R7 sticky after valid");
    round(2, 0, "R5 too few");
    round(3, 0, "R5 too many");
    round(4, 0, "R5 swapped order");
    round(0, 0, "R4 valid decrement");

    // random mix, threshold 12
    thr_m = 12; wr(0, 8'hC1);
    if (err_m > thr_m) fault_m = 1'b1;
    for (int k = 0; k < 80; k++) begin
      int kind;
      kind = ($urandom % 2 == 0) ? 0 : 1 + ($urandom % 4);
      round(kind, $urandom % 4, "R3 R4 R5 R9 random");
    end

    // R6: period 20 timed from enable edge
    wr(0, 8'hC0);
    wr(1, 8'd20); wr(2, 8'd0);
    wr(0, 8'hC1);
    wait_timeout(20, "R6 first timeout");
    wait_timeout(20, "R6 repeated timeout");
    // partial set discarded by timeout, then fresh valid set
    wr(3, ans_of(lfsr_m[3:0],3));
    wait_timeout(19, "R6 partial discarded");
    round(0, 0, "R6 valid after timeout");

    // R8: disable again, sync ignored
    wr(0, 8'hC0);
    wr(4, 8'h00);
    repeat (40) @(negedge clk);
    check_state("R8 disabled again", 1'b0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule